// File: doc/BRIEF.md
# Byte/Word Integer ALU with Condition Flags

This block is the arithmetic unit of a small accumulator-style datapath. It is purely combinational. It takes a destination operand, a source operand, a size select, the current carry flag and a 3-bit operation code. In the same cycle it returns the result, a writeback enable and six condition flags: carry, parity, auxiliary carry, zero, sign and overflow.

Eight operations share one adder:
- add and add-with-carry;
- subtract and subtract-with-borrow;
- increment and decrement;
- compare;
- two's-complement negate.

Subtraction is formed by inverting the second adder operand and the carry. All flags are taken at the selected size, either 8 or 16 bits. Two operations change the usual flag and writeback behaviour. Increment and decrement pass the incoming carry through unchanged. Compare produces the full flag set but drops the writeback enable, so neither operand is modified. The surrounding datapath registers the flags and decides where the result goes.

Top module: `int_alu`

## Requirements
- R1: Opcode 0 (add) gives dst+src. Opcode 1 (add-with-carry) gives dst+src+cf_in. Both return the sum modulo the selected size with res_we=1.
- R2: Opcode 2 (subtract) gives dst-src. Opcode 3 (subtract-with-borrow) gives dst-src-cf_in. Both return the difference modulo the selected size with res_we=1.
- R3: Opcode 4 (increment) gives dst+1 and opcode 5 (decrement) gives dst-1, both with res_we=1. For these two, cf_out equals cf_in while the other five flags follow the result.
- R4: Opcode 6 (compare) drives res_out and all six flags exactly as subtract would, with res_we=0. Equal operands give zf_out=1 and cf_out=0. An unsigned dst below src gives cf_out=1.
- R5: Opcode 7 (negate) gives 0-dst with res_we=1. cf_out is 1 exactly when dst, at the selected size, is nonzero.
- R6: For opcodes 0, 1 and 4, a carry out of the top bit of the selected size sets cf_out. For opcodes 2, 3, 5, 6 and 7, cf_out reports a borrow out of that bit. Opcodes 4 and 5 then override cf_out as stated in R3.
- R7: af_out is the carry out of bit 3 for opcodes 0, 1 and 4. For the remaining opcodes it is the borrow out of bit 3.
- R8: of_out is 1 on signed overflow at the selected size.
  - For an addition, that means the two addends have the same sign and the result sign differs.
  - For a subtraction, the operands' signs differ and the result sign differs from the minuend. For negate the minuend is 0.
- R9: zf_out is 1 when the result at the selected size is zero. sf_out is the top bit of that result. pf_out is 1 when res_out[7:0] holds an even number of ones.
- R10: With is_word=0, the upper 8 bits of dst_in and src_in have no effect on any output. In that mode res_out[15:8] is zero and all flags are taken from the 8-bit result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 compare, 7 negate |
| is_word | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| dst_in | input | 16 | Destination operand (minuend, first addend, negate/inc/dec operand) |
| src_in | input | 16 | Source operand |
| cf_in | input | 1 | Current carry flag |
| res_out | output | 16 | Result, zero-extended in byte mode |
| res_we | output | 1 | Result writeback enable |
| cf_out | output | 1 | Carry/borrow flag |
| pf_out | output | 1 | Parity flag (even ones in low byte) |
| af_out | output | 1 | Auxiliary carry/borrow out of bit 3 |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag |
| of_out | output | 1 | Signed overflow flag |

## Verification
The directed cases target the signed boundaries 0x7F/0x80 and 0x7FFF/0x8000 for add, decrement and negate:
- a design that tapped the overflow or carry at the wrong bit for the selected size would flag overflow at the other size's boundary;
- a design that computed OF as carry-out alone would misreport negate of the most negative value.

Further directed cases drive the remaining special behaviours:
- Increment of 0xFF with each carry-in value exposes a design that lets increment write CF.
- Compare with equal and with smaller destinations exposes an inverted borrow sense, or a compare that still asserts writeback.
- Byte operations with junk in the upper operand bytes expose leakage of those bits into the result or the zero flag.

Seeded random vectors at both sizes cover the bulk. They are run against a model built from integer arithmetic.

// File: rtl/int_alu_pkg.sv
// Package: shared operation encoding and flag bundle for the integer ALU.
// Assumes the opcode encoding below is fixed by the instruction decoder.
package int_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_INC = 3'd4,
        OP_DEC = 3'd5,
        OP_CMP = 3'd6,
        OP_NEG = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } alu_flags_t;

endpackage

// File: rtl/alu_operand_prep.sv
// Module: alu_operand_prep
// Maps each operation onto one shared adder: chooses the two adder inputs,
// the carry into bit 0, and whether the operation is a subtraction.
// Subtraction is a + ~b + ~borrow. Byte mode masks the upper operand bits
// to zero; the inverted operand may carry ones above the byte, which only
// affects adder bits that are later discarded.
module alu_operand_prep
    import int_alu_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int DATA_W = 16
) (
    input  alu_op_e              op,
    input  logic                 is_word,
    input  logic [DATA_W-1:0]    dst,
    input  logic [DATA_W-1:0]    src,
    input  logic                 cf_in,
    output logic [DATA_W-1:0]    add_a,
    output logic [DATA_W-1:0]    add_b,
    output logic                 add_ci,
    output logic                 is_sub
);

    localparam int HI_W = DATA_W - LANE_W;
    localparam logic [DATA_W-1:0] ONE_V = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] dst_m;
    logic [DATA_W-1:0] src_m;

    // Purpose: clear the bits above the selected operand size.
    always_comb begin
        size_mask = is_word ? {DATA_W{1'b1}} : {{HI_W{1'b0}}, {LANE_W{1'b1}}};
        dst_m     = dst & size_mask;
        src_m     = src & size_mask;
    end

    // Purpose: per-operation choice of adder inputs and carry-in.
    always_comb begin
        add_a  = dst_m;
        add_b  = src_m;
        add_ci = 1'b0;
        is_sub = 1'b0;
        unique case (op)
            OP_ADD: begin
                add_b  = src_m;
                add_ci = 1'b0;
            end
            OP_ADC: begin
                add_b  = src_m;
                add_ci = cf_in;
            end
            OP_SUB, OP_CMP: begin
                add_b  = ~src_m;
                add_ci = 1'b1;
                is_sub = 1'b1;
            end
            OP_SBB: begin
                add_b  = ~src_m;
                add_ci = ~cf_in;
                is_sub = 1'b1;
            end
            OP_INC: begin
                add_b  = ONE_V;
                add_ci = 1'b0;
            end
            OP_DEC: begin
                add_b  = ~ONE_V;
                add_ci = 1'b1;
                is_sub = 1'b1;
            end
            OP_NEG: begin
                add_a  = '0;
                add_b  = ~dst_m;
                add_ci = 1'b1;
                is_sub = 1'b1;
            end
            default: begin
                add_a  = dst_m;
                add_b  = src_m;
            end
        endcase
    end

endmodule

// File: rtl/alu_ripple_adder.sv
// Module: alu_ripple_adder
// Bit-level adder that exposes the carry into every bit position, so the
// flag stage can tap the nibble, byte and word carries directly.
// Assumes DATA_W >= 8; carries[i] is the carry into bit i,
// carries[DATA_W] the carry out of the top bit.
module alu_ripple_adder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              ci,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W:0]   carries
);

    assign carries[0] = ci;

    // Purpose: one full-adder cell per bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum[i]       = a[i] ^ b[i] ^ carries[i];
        assign carries[i+1] = (a[i] & b[i]) | (carries[i] & (a[i] ^ b[i]));
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Module: alu_flag_unit
// Forms the sized result and the six condition flags from the adder output,
// applies the carry-preserve rule of increment/decrement and the
// writeback suppression of compare. Carries are turned into borrows by
// inverting them when the operation is a subtraction.
module alu_flag_unit
    import int_alu_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int DATA_W = 16
) (
    input  alu_op_e              op,
    input  logic                 is_word,
    input  logic                 is_sub,
    input  logic                 cf_in,
    input  logic [DATA_W-1:0]    sum,
    input  logic [DATA_W:0]      carries,
    output logic [DATA_W-1:0]    result,
    output logic                 wr_en,
    output alu_flags_t           flags
);

    localparam int HI_W  = DATA_W - LANE_W;
    localparam int NIB_W = 4;

    logic carry_top;
    logic carry_msb;
    logic sign_bit;
    logic arith_cf;

    // Purpose: pick the carries and sign at the selected size.
    always_comb begin
        carry_top = is_word ? carries[DATA_W]   : carries[LANE_W];
        carry_msb = is_word ? carries[DATA_W-1] : carries[LANE_W-1];
        sign_bit  = is_word ? sum[DATA_W-1]     : sum[LANE_W-1];
        result    = is_word ? sum : {{HI_W{1'b0}}, sum[LANE_W-1:0]};
        arith_cf  = carry_top ^ is_sub;
    end

    // Purpose: flag formation with per-operation carry rule.
    always_comb begin
        flags.cf = (op == OP_INC || op == OP_DEC) ? cf_in : arith_cf;
        flags.af = carries[NIB_W] ^ is_sub;
        flags.of = carry_top ^ carry_msb;
        flags.sf = sign_bit;
        flags.zf = (result == '0);
        flags.pf = ~^result[LANE_W-1:0];
        wr_en    = (op != OP_CMP);
    end

endmodule

// File: rtl/int_alu.sv
// Module: int_alu (top)
// Combinational byte/word integer ALU with condition flags. Operand
// preparation feeds one shared ripple adder; the flag unit sizes the result
// and derives the flags. Assumes DATA_W == 2*LANE_W. The checks below sit
// beside the integration and compare outputs of separate submodules.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op_code,
    input  logic              is_word,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] src_in,
    input  logic              cf_in,
    output logic [DATA_W-1:0] res_out,
    output logic              res_we,
    output logic              cf_out,
    output logic              pf_out,
    output logic              af_out,
    output logic              zf_out,
    output logic              sf_out,
    output logic              of_out
);

    alu_op_e           op;
    logic [DATA_W-1:0] add_a;
    logic [DATA_W-1:0] add_b;
    logic              add_ci;
    logic              is_sub;
    logic [DATA_W-1:0] sum;
    logic [DATA_W:0]   carries;
    alu_flags_t        flags;

    assign op = alu_op_e'(op_code);

    alu_operand_prep #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_prep (
        .op      (op),
        .is_word (is_word),
        .dst     (dst_in),
        .src     (src_in),
        .cf_in   (cf_in),
        .add_a   (add_a),
        .add_b   (add_b),
        .add_ci  (add_ci),
        .is_sub  (is_sub)
    );

    alu_ripple_adder #(.DATA_W(DATA_W)) u_add (
        .a       (add_a),
        .b       (add_b),
        .ci      (add_ci),
        .sum     (sum),
        .carries (carries)
    );

    alu_flag_unit #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_flags (
        .op      (op),
        .is_word (is_word),
        .is_sub  (is_sub),
        .cf_in   (cf_in),
        .sum     (sum),
        .carries (carries),
        .result  (res_out),
        .wr_en   (res_we),
        .flags   (flags)
    );

    // Purpose: unpack the flag bundle onto the output pins.
    always_comb begin
        cf_out = flags.cf;
        pf_out = flags.pf;
        af_out = flags.af;
        zf_out = flags.zf;
        sf_out = flags.sf;
        of_out = flags.of;
    end

    // Purpose: guard the per-operation rules at the integration level.
    always_comb begin
        assert_cmp_no_write_R4: assert (!(op == OP_CMP) || !res_we)
            else $error("compare asserted writeback");
        assert_cf_hold_R3: assert (!(op == OP_INC || op == OP_DEC) || (cf_out == cf_in))
            else $error("inc/dec changed carry");
        assert_byte_upper_zero_R10: assert (is_word || (res_out[DATA_W-1:LANE_W] == '0))
            else $error("byte result has upper bits set");
        assert_neg_borrow_R5: assert (!(op == OP_NEG) ||
                (cf_out == (is_word ? (dst_in != '0) : (dst_in[LANE_W-1:0] != '0))))
            else $error("negate carry does not match nonzero operand");
        assert_zero_flag_R9: assert (zf_out == (res_out == '0))
            else $error("zero flag disagrees with result");
    end

endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;

    logic        clk = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        is_word = 1'b0;
    logic [15:0] dst_in = 16'h0;
    logic [15:0] src_in = 16'h0;
    logic        cf_in = 1'b0;
    logic [15:0] res_out;
    logic        res_we, cf_out, pf_out, af_out, zf_out, sf_out, of_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2 clk = ~clk;

    int_alu u0 (
        .op_code (op_code), .is_word (is_word), .dst_in (dst_in),
        .src_in  (src_in),  .cf_in   (cf_in),   .res_out (res_out),
        .res_we  (res_we),  .cf_out  (cf_out),  .pf_out  (pf_out),
        .af_out  (af_out),  .zf_out  (zf_out),  .sf_out  (sf_out),
        .of_out  (of_out)
    );

    // Reference model built from integer arithmetic per the requirements.
    function automatic void model(input logic [2:0] op, input bit w,
                                  input logic [15:0] d, input logic [15:0] s,
                                  input bit ci, output logic [15:0] r,
                                  output bit we, output bit cf, output bit pf,
                                  output bit af, output bit zf, output bit sf,
                                  output bit of);
        int n, m, dv, sv, a, b, k, tot, rv;
        bit is_add;
        n = w ? 16 : 8;
        m = w ? 65535 : 255;
        dv = int'(d) & m;
        sv = int'(s) & m;
        a = dv; b = sv; k = 0; we = 1; is_add = 1;
        case (op)
            3'd0: begin is_add = 1; end
            3'd1: begin is_add = 1; k = int'(ci); end
            3'd2: begin is_add = 0; end
            3'd3: begin is_add = 0; k = int'(ci); end
            3'd4: begin is_add = 1; b = 1; end
            3'd5: begin is_add = 0; b = 1; end
            3'd6: begin is_add = 0; we = 0; end
            default: begin is_add = 0; a = 0; b = dv; end
        endcase
        if (is_add) begin
            tot = a + b + k;
            cf  = (tot > m);
            af  = (((a & 15) + (b & 15) + k) > 15);
            rv  = tot & m;
            of  = (((a >> (n-1)) & 1) == ((b >> (n-1)) & 1)) &&
                  (((rv >> (n-1)) & 1) != ((a >> (n-1)) & 1));
        end else begin
            tot = a - b - k;
            cf  = (tot < 0);
            af  = (((a & 15) - (b & 15) - k) < 0);
            rv  = tot & m;
            of  = (((a >> (n-1)) & 1) != ((b >> (n-1)) & 1)) &&
                  (((rv >> (n-1)) & 1) != ((a >> (n-1)) & 1));
        end
        if (op == 3'd4 || op == 3'd5) cf = ci;
        r  = rv[15:0];
        zf = (rv == 0);
        sf = ((rv >> (n-1)) & 1) == 1;
        pf = ~^r[7:0];
    endfunction

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R1";
            3'd2, 3'd3: return "R2";
            3'd4, 3'd5: return "R3";
            3'd6:       return "R4";
            default:    return "R5";
        endcase
    endfunction

    task automatic apply(input logic [2:0] op, input bit w, input logic [15:0] d,
                         input logic [15:0] s, input bit ci);
        logic [15:0] er;
        bit ewe, ecf, epf, eaf, ezf, esf, eof;
        bit bad;
        string rq;
        @(posedge clk);
        op_code = op; is_word = w; dst_in = d; src_in = s; cf_in = ci;
        @(negedge clk);
        model(op, w, d, s, ci, er, ewe, ecf, epf, eaf, ezf, esf, eof);
        rq = op_req(op);
        bad = 0;
        vectors++;
        if (res_out !== er) begin
            bad = 1;
            $display("FAIL %s%s op=%0d w=%0d d=%h s=%h ci=%0d res actual=%h expected=%h",
                     rq, w ? "" : "/R10", op, w, d, s, ci, res_out, er);
        end
        if (res_we !== ewe) begin
            bad = 1;
            $display("FAIL %s/R4 op=%0d we actual=%0d expected=%0d", rq, op, res_we, ewe);
        end
        if (cf_out !== ecf) begin
            bad = 1;
            $display("FAIL R6/%s op=%0d w=%0d d=%h s=%h ci=%0d cf actual=%0d expected=%0d",
                     rq, op, w, d, s, ci, cf_out, ecf);
        end
        if (af_out !== eaf) begin
            bad = 1;
            $display("FAIL R7 op=%0d d=%h s=%h af actual=%0d expected=%0d", op, d, s, af_out, eaf);
        end
        if (of_out !== eof) begin
            bad = 1;
            $display("FAIL R8 op=%0d w=%0d d=%h s=%h of actual=%0d expected=%0d",
                     op, w, d, s, of_out, eof);
        end
        if (zf_out !== ezf || sf_out !== esf || pf_out !== epf) begin
            bad = 1;
            $display("FAIL R9 op=%0d w=%0d d=%h s=%h zsp actual=%0d%0d%0d expected=%0d%0d%0d",
                     op, w, d, s, zf_out, sf_out, pf_out, ezf, esf, epf);
        end
        if (bad) miscompares++;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250218));
        repeat (2) @(posedge clk);
        // Quiescent all-zero add: result 0, ZF=1, PF=1 (R1, R9)
        apply(3'd0, 0, 16'h0000, 16'h0000, 0);
        // R8 signed boundaries at both sizes
        apply(3'd0, 0, 16'h007F, 16'h0001, 0);
        apply(3'd0, 1, 16'h7FFF, 16'h0001, 0);
        apply(3'd2, 0, 16'h0080, 16'h0001, 0);
        apply(3'd2, 1, 16'h8000, 16'h0001, 0);
        apply(3'd5, 0, 16'h0080, 16'h0000, 1);
        apply(3'd5, 1, 16'h8000, 16'h0000, 0);
        // R5 negate corners: most negative, zero, one
        apply(3'd7, 0, 16'h0080, 16'h0000, 0);
        apply(3'd7, 1, 16'h8000, 16'h0000, 0);
        apply(3'd7, 1, 16'h0000, 16'h0000, 1);
        apply(3'd7, 0, 16'hAB00, 16'h0000, 0);
        apply(3'd7, 0, 16'h0001, 16'h0000, 0);
        // R3 increment wraps but keeps CF either way
        apply(3'd4, 0, 16'h00FF, 16'h0000, 0);
        apply(3'd4, 0, 16'h00FF, 16'h0000, 1);
        apply(3'd4, 1, 16'h7FFF, 16'h0000, 1);
        apply(3'd5, 1, 16'h0000, 16'h0000, 0);
        // R4 compare equal / smaller / larger, no writeback
        apply(3'd6, 1, 16'h1234, 16'h1234, 1);
        apply(3'd6, 1, 16'h0010, 16'h0020, 0);
        apply(3'd6, 0, 16'h0090, 16'h0010, 1);
        // R1/R2 carry-in paths and R7 nibble carry/borrow
        apply(3'd1, 0, 16'h00FF, 16'h0000, 1);
        apply(3'd1, 0, 16'h000F, 16'h0000, 1);
        apply(3'd3, 0, 16'h0000, 16'h0000, 1);
        apply(3'd3, 1, 16'h0010, 16'h000F, 1);
        // R10 junk in upper bytes must not leak in byte mode
        apply(3'd0, 0, 16'hFF00, 16'h5A00, 0);
        apply(3'd2, 0, 16'h1234, 16'hFE34, 0);
        apply(3'd6, 0, 16'hC345, 16'h1145, 0);
        // Seeded random mix across all operations and sizes
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] rd, rs;
            logic [2:0]  rop;
            bit rw, rc;
            rd  = 16'($urandom);
            rs  = 16'($urandom);
            rop = 3'($urandom % 8);
            rw  = 1'($urandom % 2);
            rc  = 1'($urandom % 2);
            apply(rop, rw, rd, rs, rc);
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule